// File: doc/BRIEF.md
# Grouped Configuration Receiver for a Two-Wire Serial Bus

This block is a write-only target on a two-wire serial bus (one clock line, one open-drain data line). A controller opens a transfer with a start condition, sends one address byte, and then streams payload bytes. The payload is a chain of three-byte groups. The two top bits of the first byte of each group select one of four group kinds. Each group kind loads a different set of configuration fields: a 15-bit main divider ratio, a 9-bit reference divider ratio, three 4-bit threshold codes, three 8-bit converter codes, charge-pump and loop-amplifier controls, three switch bits and four mode bits.

Both bus lines are sampled by a fast system clock through synchronisers. Start and stop are recognised as data-line edges while the clock line is high. Received bytes go into a staging copy of the register bank. The staged copy is transferred to the outputs only when a stop condition ends a valid transfer. A single-cycle strobe marks that commit. A sticky flag reports that both divider ratios have been fully written at least once, so the dividers may be enabled.

The bus has no flow control, because the block never stretches the clock. Every field is a plain level output, and the strobe is a plain pulse.

Top module: `twb_cfg_slave`

## Requirements
- R1: The address byte, sent MSB first, is accepted only when it equals 1100_0s00, where s (bit 2) equals `addr_sel_i`. Any other address byte is not acknowledged. The rest of that transfer up to the stop condition is then ignored: no byte is acknowledged and there is no commit strobe.
- R2: After an accepted address byte, the address byte and every later payload byte are acknowledged. The block holds the data line low through the ninth clock pulse and releases it after that pulse.
- R3: A group whose first byte has bits [7:6]=00 loads `main_ratio_o`: bits [14:12] come from byte 1 bits [2:0], bits [11:6] from byte 2 bits [5:0], and bits [5:0] from byte 3 bits [5:0].
- R4: A group headed 01 loads `ref_ratio_o` and the three thresholds. Byte 1 gives ratio bit 8 from bit 4 and `thr_rf_lvl_o` from bits [3:0]. Byte 2 gives ratio [7:4] from bits [7:4] and `thr_rf_act_o` from bits [3:0]. Byte 3 gives ratio [3:0] from bits [7:4] and `thr_if_lvl_o` from bits [3:0].
- R5: A group headed 10 carries no payload in byte 1. Byte 2 loads `dac_a_o` and byte 3 loads `dac_b_o`.
- R6: A group headed 11 loads controls from byte 1: bit 4 `loop_amp_off_o`, bit 3 `div_monitor_o`, bit 2 `pump_off_o`, bits [1:0] `pump_cur_o`. Byte 2 gives `sw_o` = {bit 7, bit 6, bit 5} and `mode_o` = bits [3:0]. Byte 3 loads `dac_c_o`.
- R7: No field output changes before the stop condition that ends its transfer. All fields change together in the single cycle in which `upd_done_o` pulses. A transfer with an accepted address that is not discarded produces exactly one such pulse.
- R8: If the stop condition falls inside the last group, the bytes of that group that completed are committed. Fields whose bytes did not arrive keep their previous values.
- R9: A repeated start inside an unfinished group discards the whole transfer. There is no commit and no strobe, and nothing is acknowledged until the stop condition.
- R10: A repeated start at a group boundary, followed by a matching address, continues the same transfer. Everything staged on both sides of the repeated start is committed at the final stop, with one strobe.
- R11: `dividers_en_o` stays low from reset until commits have included one complete 00 group and one complete 01 group, in the same transfer or in different ones. It rises in the cycle of that commit strobe and never falls afterwards.
- R12: After reset, all field outputs, `bus_dat_oe_o`, `upd_done_o` and `dividers_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock line |
| bus_dat_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 1 | Selects address bit 2 |
| bus_dat_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| main_ratio_o | output | 15 | Main divider effective ratio |
| ref_ratio_o | output | 9 | Reference divider ratio |
| thr_rf_lvl_o | output | 4 | RF level threshold code |
| thr_rf_act_o | output | 4 | RF gain-control activation threshold code |
| thr_if_lvl_o | output | 4 | IF level threshold code |
| dac_a_o | output | 8 | Converter A code |
| dac_b_o | output | 8 | Converter B code |
| dac_c_o | output | 8 | Converter C code |
| loop_amp_off_o | output | 1 | Turns the loop-filter amplifier off |
| div_monitor_o | output | 1 | Routes the divider outputs to the switch pins |
| pump_off_o | output | 1 | Turns the phase-detector charge pump off |
| pump_cur_o | output | 2 | Charge-pump current step |
| sw_o | output | 3 | Switch outputs {A,B,C} |
| mode_o | output | 4 | IF/RF mixing mode bits |
| upd_done_o | output | 1 | One-cycle commit strobe |
| dividers_en_o | output | 1 | Both divider ratios written at least once |

## Verification
The stop condition that ends a transfer does two things in the same cycle: it copies the whole staged bank to the outputs, and, if the last complete divider group has arrived, it raises the divider enable. The bench provokes this by sending the 00 group in one transfer and checking that the enable stays low. It then sends the 01 group in a later transfer and checks, right after the stop, that the enable, the strobe count and every field agree. The second collision is a repeated start against an unfinished group. The bench cuts a 11 group after two bytes, issues a repeated start, and checks that the address is refused, that no strobe appears, and that fields staged earlier in the same transfer did not reach the outputs.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int BYTE_W = 8;
  localparam int MAIN_W = 15;
  localparam int REF_W  = 9;
  localparam int THR_W  = 4;
  localparam int DAC_W  = 8;
  localparam int MODE_W = 4;
  localparam int SW_N   = 3;
  localparam int PUMP_W = 2;
  localparam int GRP_LEN = 3;
  localparam logic [4:0] ADDR_HI = 5'b11000;
  localparam logic [1:0] ADDR_LO = 2'b00;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_SKIP} phase_t;
  typedef enum logic [1:0] {GRP_A = 2'b00, GRP_B = 2'b01, GRP_C = 2'b10, GRP_D = 2'b11} grp_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_ratio;
    logic [REF_W-1:0]  ref_ratio;
    logic [THR_W-1:0]  thr_rf_lvl;
    logic [THR_W-1:0]  thr_rf_act;
    logic [THR_W-1:0]  thr_if_lvl;
    logic [DAC_W-1:0]  dac_a;
    logic [DAC_W-1:0]  dac_b;
    logic [DAC_W-1:0]  dac_c;
    logic              loop_amp_off;
    logic              div_monitor;
    logic              pump_off;
    logic [PUMP_W-1:0] pump_cur;
    logic [SW_N-1:0]   sw;
    logic [MODE_W-1:0] mode;
  } cfg_t;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  // synchroniser chains, idle bus level is high
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_o;
      sda_p <= sda_o;
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/twb_bit_rx.sv
module twb_bit_rx
  import twb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              ack_en_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_v_o,
  output logic              oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      byte_o   <= '0;
      byte_v_o <= 1'b0;
      oe_o     <= 1'b0;
    end else begin
      byte_v_o <= 1'b0;
      if (start_i || stop_i) begin
        cnt  <= '0;
        oe_o <= 1'b0;
      end else if (scl_rise_i) begin
        if (cnt < ACK_SLOT) begin
          byte_o <= {byte_o[BYTE_W-2:0], sda_i};
          cnt    <= cnt + 1'b1;
          if (cnt == LAST_BIT) byte_v_o <= 1'b1;
        end else if (cnt == ACK_SLOT) begin
          cnt <= ACK_DONE;
        end
      end else if (scl_fall_i) begin
        if (cnt == ACK_SLOT && ack_en_i) begin
          oe_o <= 1'b1;
        end else if (cnt == ACK_DONE) begin
          oe_o <= 1'b0;
          cnt  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/twb_group_dec.sv
module twb_group_dec
  import twb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_v_i,
  input  logic              addr_sel_i,
  output logic              ack_en_o,
  output cfg_t              live_o,
  output logic              upd_o,
  output logic              div_en_o
);
  localparam int POS_W = $clog2(GRP_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(GRP_LEN - 1);

  phase_t           phase;
  cfg_t             stage;
  grp_t             gtype, kind;
  logic [POS_W-1:0] gpos;
  logic             accepted, bad;
  logic             a_full_t, b_full_t, a_seen, b_seen;
  logic             addr_hit;

  assign kind     = (gpos == '0) ? grp_t'(byte_i[7:6]) : gtype;
  assign addr_hit = (byte_i == {ADDR_HI, addr_sel_i, ADDR_LO});
  assign div_en_o = a_seen & b_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      stage    <= '0;
      live_o   <= '0;
      gtype    <= GRP_A;
      gpos     <= '0;
      accepted <= 1'b0;
      bad      <= 1'b0;
      a_full_t <= 1'b0;
      b_full_t <= 1'b0;
      a_seen   <= 1'b0;
      b_seen   <= 1'b0;
      upd_o    <= 1'b0;
      ack_en_o <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (stop_i) begin
        if (accepted && !bad) begin
          live_o <= stage;
          upd_o  <= 1'b1;
          if (a_full_t) a_seen <= 1'b1;
          if (b_full_t) b_seen <= 1'b1;
        end
        phase    <= PH_IDLE;
        accepted <= 1'b0;
        bad      <= 1'b0;
        gpos     <= '0;
        a_full_t <= 1'b0;
        b_full_t <= 1'b0;
        ack_en_o <= 1'b0;
      end else if (start_i) begin
        ack_en_o <= 1'b0;
        if (phase == PH_IDLE) begin
          stage <= live_o;
          gpos  <= '0;
          phase <= PH_ADDR;
        end else if (gpos != '0) begin
          bad   <= 1'b1;
          phase <= PH_SKIP;
        end else if (!bad) begin
          phase <= PH_ADDR;
        end
      end else if (byte_v_i) begin
        unique case (phase)
          PH_ADDR: begin
            if (addr_hit) begin
              phase    <= PH_DATA;
              accepted <= 1'b1;
              ack_en_o <= 1'b1;
            end else begin
              phase    <= PH_SKIP;
              ack_en_o <= 1'b0;
            end
          end
          PH_DATA: begin
            ack_en_o <= 1'b1;
            gtype    <= kind;
            gpos     <= (gpos == POS_LAST) ? '0 : gpos + 1'b1;
            unique case (kind)
              GRP_A: begin
                if (gpos == 2'd0) stage.main_ratio[14:12] <= byte_i[2:0];
                if (gpos == 2'd1) stage.main_ratio[11:6]  <= byte_i[5:0];
                if (gpos == 2'd2) begin
                  stage.main_ratio[5:0] <= byte_i[5:0];
                  a_full_t <= 1'b1;
                end
              end
              GRP_B: begin
                if (gpos == 2'd0) begin
                  stage.ref_ratio[8] <= byte_i[4];
                  stage.thr_rf_lvl   <= byte_i[3:0];
                end
                if (gpos == 2'd1) begin
                  stage.ref_ratio[7:4] <= byte_i[7:4];
                  stage.thr_rf_act     <= byte_i[3:0];
                end
                if (gpos == 2'd2) begin
                  stage.ref_ratio[3:0] <= byte_i[7:4];
                  stage.thr_if_lvl     <= byte_i[3:0];
                  b_full_t <= 1'b1;
                end
              end
              GRP_C: begin
                if (gpos == 2'd1) stage.dac_a <= byte_i;
                if (gpos == 2'd2) stage.dac_b <= byte_i;
              end
              GRP_D: begin
                if (gpos == 2'd0) begin
                  stage.loop_amp_off <= byte_i[4];
                  stage.div_monitor  <= byte_i[3];
                  stage.pump_off     <= byte_i[2];
                  stage.pump_cur     <= byte_i[1:0];
                end
                if (gpos == 2'd1) begin
                  stage.sw   <= byte_i[7:5];
                  stage.mode <= byte_i[3:0];
                end
                if (gpos == 2'd2) stage.dac_c <= byte_i;
              end
            endcase
          end
          default: ack_en_o <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/twb_cfg_slave.sv
module twb_cfg_slave
  import twb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic              addr_sel_i,
  output logic              bus_dat_oe_o,
  output logic [MAIN_W-1:0] main_ratio_o,
  output logic [REF_W-1:0]  ref_ratio_o,
  output logic [THR_W-1:0]  thr_rf_lvl_o,
  output logic [THR_W-1:0]  thr_rf_act_o,
  output logic [THR_W-1:0]  thr_if_lvl_o,
  output logic [DAC_W-1:0]  dac_a_o,
  output logic [DAC_W-1:0]  dac_b_o,
  output logic [DAC_W-1:0]  dac_c_o,
  output logic              loop_amp_off_o,
  output logic              div_monitor_o,
  output logic              pump_off_o,
  output logic [PUMP_W-1:0] pump_cur_o,
  output logic [SW_N-1:0]   sw_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              upd_done_o,
  output logic              dividers_en_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_v, ack_en;
  cfg_t live_cfg;

  twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_clk_i), .sda_i(bus_dat_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  twb_bit_rx u_rx (
    .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .sda_i(sda_s), .ack_en_i(ack_en),
    .byte_o(rx_byte), .byte_v_o(rx_v), .oe_o(bus_dat_oe_o)
  );

  twb_group_dec u_dec (
    .clk(clk), .rst_n(rst_n), .start_i(bus_start), .stop_i(bus_stop),
    .byte_i(rx_byte), .byte_v_i(rx_v), .addr_sel_i(addr_sel_i),
    .ack_en_o(ack_en), .live_o(live_cfg), .upd_o(upd_done_o), .div_en_o(dividers_en_o)
  );

  assign main_ratio_o   = live_cfg.main_ratio;
  assign ref_ratio_o    = live_cfg.ref_ratio;
  assign thr_rf_lvl_o   = live_cfg.thr_rf_lvl;
  assign thr_rf_act_o   = live_cfg.thr_rf_act;
  assign thr_if_lvl_o   = live_cfg.thr_if_lvl;
  assign dac_a_o        = live_cfg.dac_a;
  assign dac_b_o        = live_cfg.dac_b;
  assign dac_c_o        = live_cfg.dac_c;
  assign loop_amp_off_o = live_cfg.loop_amp_off;
  assign div_monitor_o  = live_cfg.div_monitor;
  assign pump_off_o     = live_cfg.pump_off;
  assign pump_cur_o     = live_cfg.pump_cur;
  assign sw_o           = live_cfg.sw;
  assign mode_o         = live_cfg.mode;
endmodule

// File: rtl/twb_cfg_slave_chk.sv
module twb_cfg_slave_chk #(
  parameter int CFG_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             oe,
  input logic             upd,
  input logic             div_en,
  input logic [CFG_W-1:0] cfg
);
  // R2
  ack_on_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_s);
  // R7
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(cfg));
  // R7
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
  // R11
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |=> div_en);
  // R11
  en_with_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_en) |-> upd);
endmodule

bind twb_cfg_slave twb_cfg_slave_chk #(.CFG_W($bits(twb_pkg::cfg_t))) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .oe(bus_dat_oe_o),
  .upd(upd_done_o), .div_en(dividers_en_o), .cfg(live_cfg)
);

// File: tb/twb_cfg_slave_test.sv
`timescale 1ns/1ps
module twb_cfg_slave_test;
  localparam int Q = 8;

  typedef struct packed {
    logic [14:0] mr; logic [8:0] rr;
    logic [3:0] t1, t2, t3;
    logic [7:0] da, db, dc;
    logic amp, mon, poff; logic [1:0] pc;
    logic [2:0] sw; logic [3:0] md;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic tb_scl = 1, tb_sda = 1, addr_sel = 1;
  wire  oe;
  wire  sda_line = tb_sda & ~oe;
  logic [14:0] mr; logic [8:0] rr; logic [3:0] t1, t2, t3;
  logic [7:0] da, db, dc; logic amp, mon, poff; logic [1:0] pc;
  logic [2:0] sw; logic [3:0] md; logic upd, den;
  int total = 0, bad = 0, upd_cnt = 0;
  exp_t e, p;

  always #2.5 clk = ~clk;

  twb_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(tb_scl), .bus_dat_i(sda_line), .addr_sel_i(addr_sel),
    .bus_dat_oe_o(oe), .main_ratio_o(mr), .ref_ratio_o(rr), .thr_rf_lvl_o(t1),
    .thr_rf_act_o(t2), .thr_if_lvl_o(t3), .dac_a_o(da), .dac_b_o(db), .dac_c_o(dc),
    .loop_amp_off_o(amp), .div_monitor_o(mon), .pump_off_o(poff), .pump_cur_o(pc),
    .sw_o(sw), .mode_o(md), .upd_done_o(upd), .dividers_en_o(den)
  );

  always @(posedge clk) if (rst_n && upd) upd_cnt <= upd_cnt + 1;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    check(req, "main", 32'(mr), 32'(e.mr));  check(req, "ref", 32'(rr), 32'(e.rr));
    check(req, "thr", {20'd0, t1, t2, t3}, {20'd0, e.t1, e.t2, e.t3});
    check(req, "dacs", {8'd0, da, db, dc}, {8'd0, e.da, e.db, e.dc});
    check(req, "ctl", {27'd0, amp, mon, poff, pc}, {27'd0, e.amp, e.mon, e.poff, e.pc});
    check(req, "swmode", {25'd0, sw, md}, {25'd0, e.sw, e.md});
  endtask

  task automatic wq(input int n); repeat (n * Q) @(negedge clk); endtask

  task automatic start_c(); tb_sda = 0; wq(1); tb_scl = 0; wq(1); endtask
  task automatic stop_c(); tb_sda = 0; wq(1); tb_scl = 1; wq(1); tb_sda = 1; wq(1); endtask
  task automatic rstart_c(); tb_sda = 1; wq(1); tb_scl = 1; wq(1); tb_sda = 0; wq(1); tb_scl = 0; wq(1); endtask

  task automatic sendx(input logic [7:0] b, input logic exp_ack, input string req);
    logic ab;
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; wq(1); tb_scl = 1; wq(2); tb_scl = 0; wq(1);
    end
    tb_sda = 1; wq(1); tb_scl = 1; wq(1); ab = sda_line; wq(1); tb_scl = 0; wq(1);
    check(req, "ack", 32'(ab), exp_ack ? 32'd0 : 32'd1);
  endtask

  function automatic logic [7:0] adr(input logic s); return {5'b11000, s, 2'b00}; endfunction

  task automatic begin_x(); start_c(); p = e; sendx(adr(addr_sel), 1'b1, "R1"); endtask
  task automatic end_x(input logic commit); stop_c(); wq(1); if (commit) e = p; endtask

  task automatic grp_a(input logic [14:0] n);
    sendx({5'b00000, n[14:12]}, 1'b1, "R2"); sendx({2'b00, n[11:6]}, 1'b1, "R2");
    sendx({2'b00, n[5:0]}, 1'b1, "R2"); p.mr = n;
  endtask
  task automatic grp_b(input logic [8:0] r, input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    sendx({3'b010, r[8], a}, 1'b1, "R2"); sendx({r[7:4], b}, 1'b1, "R2");
    sendx({r[3:0], c}, 1'b1, "R2"); p.rr = r; p.t1 = a; p.t2 = b; p.t3 = c;
  endtask
  task automatic grp_c(input logic [7:0] a, input logic [7:0] b);
    sendx(8'h80, 1'b1, "R2"); sendx(a, 1'b1, "R2"); sendx(b, 1'b1, "R2"); p.da = a; p.db = b;
  endtask
  task automatic grp_d(input logic [4:0] c, input logic [2:0] s, input logic [3:0] m, input logic [7:0] v);
    sendx({3'b110, c}, 1'b1, "R2"); sendx({s, 1'b0, m}, 1'b1, "R2"); sendx(v, 1'b1, "R2");
    p.amp = c[4]; p.mon = c[3]; p.poff = c[2]; p.pc = c[1:0]; p.sw = s; p.md = m; p.dc = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int u0;
    e = '0;
    repeat (5) @(negedge clk); rst_n = 1; wq(1);
    // R12 reset state
    chk_all("R12");
    check("R12", "oe/upd/en", {29'd0, oe, upd, den}, 32'd0);

    // R1 address sweep over select pin and address bit 2
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 2; a++) begin
        addr_sel = s[0]; u0 = upd_cnt;
        start_c(); p = e;
        sendx(adr(a[0]), a == s, "R1");
        sendx(8'h80, a == s, "R1");
        end_x(1'b0);
        check("R1", "strobes", 32'(upd_cnt - u0), (a == s) ? 32'd1 : 32'd0);
      end
    end
    addr_sel = 1;
    start_c(); sendx(8'hCC, 1'b0, "R1"); sendx(8'h80, 1'b0, "R1"); end_x(1'b0);

    // R3 / R11: divider A alone, enable still low
    begin_x(); grp_a(15'h1234);
    check("R7", "main before stop", 32'(mr), 32'(e.mr));
    end_x(1'b1);
    chk_all("R3");
    check("R11", "en after A only", 32'(den), 32'd0);

    // R4 / R11: B completes, enable rises on that commit
    u0 = upd_cnt;
    begin_x(); grp_b(9'h1A5, 4'h3, 4'hC, 4'h9); end_x(1'b1);
    chk_all("R4");
    check("R11", "en after A and B", 32'(den), 32'd1);
    check("R7", "one strobe", 32'(upd_cnt - u0), 32'd1);

    // R3 / R4 sweep of ratio values
    for (int k = 0; k < 8; k++) begin
      begin_x();
      grp_a(15'h0800 + 15'(k * 15'h0F1D));
      grp_b(9'(k * 9'h049 + 1), 4'(k), 4'(15 - k), 4'(k * 3));
      end_x(1'b1);
      chk_all("R3");
      check("R11", "en held", 32'(den), 32'd1);
    end

    // R5 and R6 sweep of control patterns
    for (int i = 0; i < 32; i++) begin
      begin_x();
      grp_d(5'(i), 3'(i) ^ 3'b101, 4'(i + 3), 8'(i * 37));
      grp_c(8'(i * 11), 8'(255 - i));
      end_x(1'b1);
      chk_all("R6");
    end

    // R8 stop inside last group
    begin_x(); sendx(8'h80, 1'b1, "R8"); sendx(8'h5A, 1'b1, "R8"); p.da = 8'h5A;
    end_x(1'b1);
    chk_all("R8");
    begin_x(); grp_c(8'h11, 8'h22); sendx(8'hC7, 1'b1, "R8"); p.amp = 0; p.mon = 0; p.poff = 1; p.pc = 2'b11;
    end_x(1'b1);
    chk_all("R8");

    // R9 repeated start inside unfinished group discards everything
    u0 = upd_cnt;
    begin_x(); grp_c(8'hE1, 8'hE2); sendx(8'hDF, 1'b1, "R9"); sendx(8'hFF, 1'b1, "R9");
    rstart_c(); sendx(adr(1'b1), 1'b0, "R9"); sendx(8'h80, 1'b0, "R9");
    end_x(1'b0);
    chk_all("R9");
    check("R9", "strobes", 32'(upd_cnt - u0), 32'd0);

    // R10 repeated start at boundary continues transfer
    u0 = upd_cnt;
    begin_x(); grp_c(8'h3C, 8'hC3); rstart_c(); sendx(adr(1'b1), 1'b1, "R10");
    grp_a(15'h7FFF);
    check("R7", "dac before stop", 32'(da), 32'(e.da));
    end_x(1'b1);
    chk_all("R10");
    check("R10", "strobes", 32'(upd_cnt - u0), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule